// File: doc/BRIEF.md
# Quad-SPI clock and select engine

This block is the bit-level core of a serial flash master. It takes entries of up to four bytes from a transmit FIFO and sends them one bit at a time. It drives a serial clock divided from the reference clock by a power of two, and it assembles the bytes it receives on the input line into a 32-bit word for a receive FIFO. Clock polarity and clock phase are set from configuration inputs. The chip-select lines are either held by software or opened only for the length of each entry.

Software sets the divider exponent, the polarity, the phase, the select pattern and the start mode. It then fills the transmit FIFO. In automatic mode the engine takes an entry as soon as one is present. In manual mode it waits for a one-cycle start pulse, and after that pulse it keeps taking entries until the FIFO runs dry. Only the single data lane is handled.

Top module: `qspi_seq_engine`

## Requirements
- R1: After reset, `rx_push` and `tx_pop` are low, `mosi` is 0, `sclk` equals `cfg_cpol`, and with `cfg_cs_force`=0 every `cs_n` line is high.
- R2: Every half period of `sclk` during a transfer lasts 2^`cfg_div` clock cycles. An entry of n bytes produces 16·n edges, and `rx_push` rises exactly 16·n·2^`cfg_div` cycles after the clock edge that pops the entry.
- R3: `sclk` rests at the `cfg_cpol` level when idle and is back at that level when `rx_push` rises.
- R4: With `cfg_cpha`=0 each bit is on `mosi` before its first (leading) edge and `miso` is sampled on that edge. With `cfg_cpha`=1 `mosi` changes on the leading edge and `miso` is sampled on the trailing edge.
- R5: The bytes of an entry are sent starting from `tx_data[7:0]` and moving to higher bytes, each byte most significant bit first.
- R6: When an entry of n bytes finishes, `rx_push` pulses for one cycle. Received byte k (k=0 first) sits in `rx_data` byte lane 4-n+k, each byte most significant bit first, and the lanes below 4-n are zero.
- R7: With `cfg_man_start_en`=0 and `cfg_en`=1, `tx_pop` is high in every idle cycle in which `tx_valid` is high, and never when `tx_valid` is low.
- R8: With `cfg_man_start_en`=1, a waiting entry is not popped until `man_start` is pulsed. The pulse pops it in that same cycle.
- R9: With `cfg_cs_force`=1, `cs_n` equals `cfg_cs_sel` at all times. With `cfg_cs_force`=0, `cs_n` equals `cfg_cs_sel` while a transfer runs and is all ones otherwise. The select lines are active low.
- R10: With `cfg_en`=0 no entry is popped.
- R11: `tx_nbytes` code 0 means four bytes, and codes 1 to 3 mean that many bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Master enable |
| cfg_div | input | DIVW | Divider exponent; sclk = clk / (2 << cfg_div) |
| cfg_cpol | input | 1 | Idle level of sclk |
| cfg_cpha | input | 1 | Sample on trailing edge when 1 |
| cfg_cs_force | input | 1 | Hold cs_n at cfg_cs_sel even when idle |
| cfg_cs_sel | input | NCS | Active-low select pattern |
| cfg_man_start_en | input | 1 | Require a start pulse before popping |
| man_start | input | 1 | One-cycle start pulse |
| tx_valid | input | 1 | Transmit FIFO holds an entry |
| tx_data | input | 32 | Entry data, first byte in bits [7:0] |
| tx_nbytes | input | 2 | Byte count, 0 means 4 |
| tx_pop | output | 1 | Entry taken this cycle |
| rx_push | output | 1 | rx_data valid this cycle |
| rx_data | output | 32 | Received word |
| sclk | output | 1 | Serial clock |
| cs_n | output | NCS | Chip selects, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
`tx_pop` is combinational, so the bench tests it 1 ns after it changes its inputs, before the next rising edge. Every sclk edge, mosi change and miso sample lands on a rising clock edge. The bench therefore reads all outputs and drives miso on the falling edge, and counts sclk edges from the levels it sees there. The end of a transfer is timed by counting falling edges from the pop. `rx_push` must appear on falling edge number 16·n·2^div + 1, and `rx_data` and the rest level of sclk are read on that same edge. The bench sweeps three divider values, both polarities, both phases and all four byte counts, and adds one run at the slowest divider.

// File: rtl/qspi_seq_engine.sv
module qspi_seq_engine #(
  parameter int DIVW = 3,
  parameter int NCS  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic [DIVW-1:0] cfg_div,
  input  logic            cfg_cpol,
  input  logic            cfg_cpha,
  input  logic            cfg_cs_force,
  input  logic [NCS-1:0]  cfg_cs_sel,
  input  logic            cfg_man_start_en,
  input  logic            man_start,
  input  logic            tx_valid,
  input  logic [31:0]     tx_data,
  input  logic [1:0]      tx_nbytes,
  output logic            tx_pop,
  output logic            rx_push,
  output logic [31:0]     rx_data,
  output logic            sclk,
  output logic [NCS-1:0]  cs_n,
  output logic            mosi,
  input  logic            miso
);
  localparam int CNTW = 1 << DIVW;

  logic            busy, lvl, armed, cpol_l, cpha_l;
  logic [DIVW-1:0] div_l;
  logic [CNTW-1:0] dcnt, lim;
  logic [6:0]      ecnt, elast, eadj;
  logic [4:0]      bidx;
  logic [31:0]     txs, rxw, rxw_n;
  logic [7:0]      rbyte, rb_n;
  logic [2:0]      nb;
  logic            edge_now, samp, bdone, last, go;

  assign lim      = (CNTW'(1) << div_l) - CNTW'(1);
  assign edge_now = busy && (dcnt == lim);
  assign samp     = edge_now && (ecnt[0] == cpha_l);
  assign rb_n     = {rbyte[6:0], miso};
  assign bdone    = samp && (ecnt[3:1] == 3'd7);
  assign rxw_n    = bdone ? {rb_n, rxw[31:8]} : rxw;
  assign last     = edge_now && (ecnt == elast);
  assign go       = !cfg_man_start_en || armed || man_start;
  assign tx_pop   = cfg_en && !busy && tx_valid && go;
  assign nb       = (tx_nbytes == 2'd0) ? 3'd4 : {1'b0, tx_nbytes};

  assign eadj = (cpha_l && ecnt != 7'd0) ? ecnt - 7'd1 : ecnt;
  assign bidx = 5'(eadj >> 1);

  assign mosi = busy & txs[5'd31 - bidx];
  assign sclk = busy ? (cpol_l ^ lvl) : cfg_cpol;
  assign cs_n = (cfg_cs_force || busy) ? cfg_cs_sel : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      lvl     <= 1'b0;
      armed   <= 1'b0;
      cpol_l  <= 1'b0;
      cpha_l  <= 1'b0;
      div_l   <= '0;
      dcnt    <= '0;
      ecnt    <= '0;
      elast   <= '0;
      txs     <= '0;
      rxw     <= '0;
      rbyte   <= '0;
      rx_push <= 1'b0;
      rx_data <= '0;
    end else begin
      rx_push <= 1'b0;
      armed   <= man_start | (armed & (busy | tx_valid));
      if (tx_pop) begin
        busy   <= 1'b1;
        lvl    <= 1'b0;
        dcnt   <= '0;
        ecnt   <= '0;
        elast  <= {nb, 4'b0000} - 7'd1;
        txs    <= {tx_data[7:0], tx_data[15:8], tx_data[23:16], tx_data[31:24]};
        rxw    <= '0;
        rbyte  <= '0;
        cpol_l <= cfg_cpol;
        cpha_l <= cfg_cpha;
        div_l  <= cfg_div;
      end else if (busy) begin
        if (edge_now) begin
          dcnt <= '0;
          lvl  <= ~lvl;
          ecnt <= ecnt + 7'd1;
          rxw  <= rxw_n;
          if (samp) rbyte <= rb_n;
          if (last) begin
            busy    <= 1'b0;
            rx_push <= 1'b1;
            rx_data <= rxw_n;
          end
        end else begin
          dcnt <= dcnt + CNTW'(1);
        end
      end
    end
  end
endmodule

module qspi_seq_engine_chk #(
  parameter int DIVW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_en,
  input logic            tx_valid,
  input logic            tx_pop,
  input logic            rx_push,
  input logic            busy,
  input logic            lvl,
  input logic [DIVW-1:0] div_l,
  input logic [(1<<DIVW)-1:0] dcnt
);
  localparam int CNTW = 1 << DIVW;
  logic [CNTW-1:0] lim_c;
  assign lim_c = (CNTW'(1) << div_l) - CNTW'(1);

  // R7
  pop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> tx_valid);
  // R7
  pop_starts_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> busy);
  // R6
  push_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push);
  // R10
  disabled_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> !tx_pop);
  // R2
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dcnt != lim_c) |=> $stable(lvl));
endmodule

bind qspi_seq_engine qspi_seq_engine_chk #(.DIVW(DIVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .tx_valid(tx_valid),
  .tx_pop(tx_pop), .rx_push(rx_push), .busy(busy), .lvl(lvl),
  .div_l(div_l), .dcnt(dcnt)
);

// File: tb/qspi_seq_engine_bench.sv
module qspi_seq_engine_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_en = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic        cfg_cs_force = 1'b0, cfg_man_start_en = 1'b0, man_start = 1'b0;
  logic [2:0]  cfg_div = 3'd0;
  logic [1:0]  cfg_cs_sel = 2'b10;
  logic        tx_valid = 1'b0, miso = 1'b0;
  logic [31:0] tx_data = '0;
  logic [1:0]  tx_nbytes = 2'd0;
  logic        tx_pop, rx_push, sclk, mosi;
  logic [31:0] rx_data;
  logic [1:0]  cs_n;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  qspi_seq_engine u_qspi_seq_engine (.*);

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bit_at(input int edges, input bit cpha);
    int adj;
    adj = (cpha && edges != 0) ? edges - 1 : edges;
    return adj / 2;
  endfunction

  task automatic xfer(input int div, input bit cpol, input bit cpha, input int code,
                      input logic [31:0] data, input logic [31:0] spat,
                      input bit forced, input bit man);
    int n, len, cyc, edges, bi, early;
    bit prev, bad_mosi, bad_cs, popped;
    logic [31:0] exp_rx;
    n = (code == 0) ? 4 : code;
    len = 16 * n * (1 << div);
    @(negedge clk);
    cfg_div = 3'(div); cfg_cpol = cpol; cfg_cpha = cpha; cfg_cs_force = forced;
    cfg_man_start_en = man; tx_data = data; tx_nbytes = 2'(code); tx_valid = 1'b1;
    miso = spat[7];
    if (man) begin
      early = 0;
      for (int i = 0; i < 20; i++) begin #1; if (tx_pop) early++; @(negedge clk); end
      chk(early == 0, "R8 no pop before start", 32'(early), 0);
      man_start = 1'b1;
    end
    popped = 0;
    for (int i = 0; i < 40; i++) begin
      #1;
      if (tx_pop) begin popped = 1; break; end
      @(negedge clk);
    end
    chk(popped, man ? "R8 pop on start pulse" : "R7 auto pop", 32'(popped), 1);
    @(posedge clk); #1;
    tx_valid = 1'b0; man_start = 1'b0;
    cyc = 0; edges = 0; prev = cpol; bad_mosi = 0; bad_cs = 0;
    while (cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (sclk != prev) begin edges++; prev = sclk; end
      if (rx_push) break;
      bi = bit_at(edges, cpha);
      if (bi < 32 && mosi !== data[8*(bi/8) + 7 - bi%8]) bad_mosi = 1;
      if (cs_n !== cfg_cs_sel) bad_cs = 1;
      if (bi < 32) miso = spat[8*(bi/8) + 7 - bi%8];
    end
    chk(cyc == len + 1, "R2 R11 transfer length", 32'(cyc), 32'(len + 1));
    chk(edges == 16 * n, "R2 edge count", 32'(edges), 32'(16 * n));
    chk(!bad_mosi, "R4 R5 mosi bit order", 32'(bad_mosi), 0);
    chk(!bad_cs, "R9 select during transfer", 32'(bad_cs), 0);
    chk(sclk == cpol, "R3 sclk rest level", 32'(sclk), 32'(cpol));
    exp_rx = '0;
    for (int k = 0; k < n; k++) exp_rx[8*(4-n+k) +: 8] = spat[8*k +: 8];
    chk(rx_data == exp_rx, "R4 R6 received word", rx_data, exp_rx);
    @(negedge clk);
    chk(!rx_push, "R6 push one cycle", 32'(rx_push), 0);
    chk(cs_n == (forced ? cfg_cs_sel : 2'b11), "R9 select after transfer", 32'(cs_n),
        32'(forced ? cfg_cs_sel : 2'b11));
  endtask

  initial begin
    int early;
    #1;
    chk(!tx_pop && !rx_push && mosi == 1'b0, "R1 reset outputs", {tx_pop, rx_push, mosi}, 0);
    chk(cs_n == 2'b11 && sclk == 1'b0, "R1 reset select and clock", {cs_n, sclk}, 32'b110);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int div = 0; div < 3; div++)
      for (int m = 0; m < 4; m++)
        for (int code = 0; code < 4; code++)
          xfer(div, m[1], m[0], code, 32'h9E37_79B9 * (div * 16 + m * 4 + code + 1),
               32'hC2B2_AE35 ^ (32'h0101_0101 * (div * 16 + m * 4 + code)), 1'b0, 1'b0);
    xfer(7, 1'b1, 1'b0, 1, 32'h0000_00A5, 32'h0000_003C, 1'b0, 1'b0);
    xfer(1, 1'b0, 1'b1, 2, 32'h1234_5678, 32'h8765_4321, 1'b1, 1'b0);
    @(negedge clk);
    chk(cs_n == cfg_cs_sel, "R9 forced select idle", 32'(cs_n), 32'(cfg_cs_sel));
    cfg_cpol = 1'b1; #1;
    chk(sclk == 1'b1, "R3 idle sclk follows polarity", 32'(sclk), 1);
    xfer(0, 1'b0, 1'b0, 3, 32'h00FF_00FF, 32'h00AB_CDEF, 1'b0, 1'b1);
    xfer(2, 1'b1, 1'b1, 0, 32'hDEAD_BEEF, 32'hF00D_CAFE, 1'b0, 1'b1);
    @(negedge clk);
    cfg_man_start_en = 1'b0; cfg_en = 1'b0; tx_valid = 1'b1;
    early = 0;
    for (int i = 0; i < 20; i++) begin #1; if (tx_pop) early++; @(negedge clk); end
    chk(early == 0, "R10 disabled no pop", 32'(early), 0);
    tx_valid = 1'b0; #1;
    chk(!tx_pop, "R7 no pop without entry", 32'(tx_pop), 0);
    cfg_en = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule